// File: doc/BRIEF.md
# Enhanced-Mode Register File with Parameter RAM

This block is the register file that a disk controller uses once its legacy personality has been unlocked into the enhanced personality. It holds three things. The first is an 8-bit phase register. The second is a mode register that software changes through two addresses: one clears the bits written as 1, the other sets them. The third is a small parameter RAM. Software walks that RAM through a hidden index, which steps after every parameter read or write.

A status read reports the active personality in bit 6. When a write to the clear address leaves mode bit 6 at 0, the block gives control back. It drops its active flag and sends a one-cycle request to the legacy decoder to clear its latches. The parameter RAM keeps its contents across such a handoff.

The data, mark, CRC, error and setup locations are placeholders. They read as zero and ignore writes.

Top module: `enh_regfile`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0x00, `enh_active` is 0 and `legacy_clr_req` is 0. The mode register, the phase register, the parameter index and the parameter RAM entries are all zero.
- R2: A cycle with `unlock_in` high while inactive makes `enh_active` 1 after that edge and sets mode bit 6. While the block is already active, `unlock_in` has no effect.
- R3: A write to address 6 (mode clear) replaces the mode register with mode AND NOT `wr_data`.
- R4: A write to address 7 (mode set) replaces the mode register with mode OR `wr_data`. The mode register reads back at address 15.
- R5: Every write to address 6 resets the parameter index to 0, whatever value is written, including 0x00.
- R6: When a mode-clear write leaves mode bit 6 at 0, two things happen after that edge: `enh_active` falls, and `legacy_clr_req` is high for exactly one cycle. Parameter RAM contents are kept.
- R7: A write to address 3 stores `wr_data` in the parameter RAM entry at the current index. The index then advances by one, modulo 16.
- R8: A read of address 11 returns the parameter entry at the current index. The index then advances by one, modulo 16.
- R9: A read of address 14 (status) returns 0x40 while active. Bit 6 carries the active flag, and every other status bit is zero.
- R10: Reads of addresses 8, 9, 10 and 13 (data, mark, error, setup) return 0x00. Writes to addresses 0, 1, 2 and 5 (data, mark, CRC, setup) change no readable state.
- R11: While inactive, every register access is ignored and `rd_data` stays 0x00.
- R12: The read result appears on `rd_data` in the cycle after `rd_en`, and `rd_data` is 0x00 in any cycle that follows no read. If `wr_en` and `rd_en` are both high, only the write takes effect.
- R13: A write to address 4 loads the phase register, which reads back at address 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unlock_in | input | 1 | Pulse from the legacy decoder: unlock sequence complete |
| reg_addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| enh_active | output | 1 | Enhanced personality owns the register map |
| legacy_clr_req | output | 1 | One-cycle request to clear the legacy latches on handoff |

## Verification
On every cycle, the assertions check the following:
- the handoff pulse: it lasts one cycle and coincides with the active flag falling;
- the zero read result after idle, inactive and placeholder accesses;
- the status value;
- the index stepping and wrap on parameter accesses;
- the index reset on each mode-clear write.

Some behaviour only the bench scenarios can show, because the bench's reference model tracks the full state. This covers:
- the contents read back from the parameter RAM after wrap-around and after a handoff;
- the clear-bits and set-bits arithmetic on the mode register;
- that ignored writes leave the phase, the mode and the RAM untouched.

// File: rtl/enh_regs_pkg.sv
// Package: shared address map and access-strobe type for the enhanced-mode
// register file. Assumes a 4-bit register address with disjoint write
// (0-7) and read (8-15) halves.
package enh_regs_pkg;

    localparam int unsigned ADDR_W = 4;

    // Write-side addresses
    localparam logic [ADDR_W-1:0] A_WR_DATA  = 4'd0;
    localparam logic [ADDR_W-1:0] A_WR_MARK  = 4'd1;
    localparam logic [ADDR_W-1:0] A_WR_CRC   = 4'd2;
    localparam logic [ADDR_W-1:0] A_WR_PARAM = 4'd3;
    localparam logic [ADDR_W-1:0] A_WR_PHASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_WR_SETUP = 4'd5;
    localparam logic [ADDR_W-1:0] A_WR_MCLR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_WR_MSET  = 4'd7;

    // Read-side addresses
    localparam logic [ADDR_W-1:0] A_RD_DATA   = 4'd8;
    localparam logic [ADDR_W-1:0] A_RD_MARK   = 4'd9;
    localparam logic [ADDR_W-1:0] A_RD_ERROR  = 4'd10;
    localparam logic [ADDR_W-1:0] A_RD_PARAM  = 4'd11;
    localparam logic [ADDR_W-1:0] A_RD_PHASE  = 4'd12;
    localparam logic [ADDR_W-1:0] A_RD_SETUP  = 4'd13;
    localparam logic [ADDR_W-1:0] A_RD_STATUS = 4'd14;
    localparam logic [ADDR_W-1:0] A_RD_MODE   = 4'd15;

    // Qualified access strobes produced by the decoder
    typedef struct packed {
        logic mode_clr;
        logic mode_set;
        logic phase_wr;
        logic pram_wr;
        logic pram_rd;
        logic rd_ok;
    } acc_t;

endpackage

// File: rtl/enh_access_dec.sv
// Module: enh_access_dec
// Turns the raw strobes and address into qualified one-hot access strobes.
// Assumes accesses count only while the enhanced personality is active,
// and that a write wins over a read issued in the same cycle.
module enh_access_dec
    import enh_regs_pkg::*;
(
    input  logic              active,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);

    logic wr_ok;
    logic rd_ok;

    // Qualify strobes with the active flag and the write-over-read priority
    always_comb begin
        wr_ok        = active & wr_en;
        rd_ok        = active & rd_en & ~wr_en;
        acc.mode_clr = wr_ok & (addr == A_WR_MCLR);
        acc.mode_set = wr_ok & (addr == A_WR_MSET);
        acc.phase_wr = wr_ok & (addr == A_WR_PHASE);
        acc.pram_wr  = wr_ok & (addr == A_WR_PARAM);
        acc.pram_rd  = rd_ok & (addr == A_RD_PARAM);
        acc.rd_ok    = rd_ok;
    end

endmodule

// File: rtl/enh_param_ram.sv
// Module: enh_param_ram
// Parameter RAM with an auto-advancing index. Every read or write steps
// the index modulo DEPTH; a clear request forces it to zero and takes
// priority. Assumes wr and rd are never both high (decoder guarantees).
module enh_param_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              idx_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];

    // Index: clear on request, otherwise advance and wrap on each access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (idx_clr) begin
            idx <= '0;
        end else if (wr | rd) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    // One storage register per entry, written when the index selects it
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr && (idx == IDX_W'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/enh_mode_ctrl.sv
// Module: enh_mode_ctrl
// Mode register with separate clear-bits and set-bits updates, plus the
// personality flag. Entry comes from the legacy unlock pulse; a clear
// that drops bit STAT_BIT hands control back and pulses legacy_clr.
// Assumes clr and set strobes are mutually exclusive.
module enh_mode_ctrl #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STAT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock,
    input  logic              clr_stb,
    input  logic              set_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode,
    output logic              active,
    output logic              legacy_clr
);

    localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;

    logic [DATA_W-1:0] cleared;

    // Value the mode register takes on a clear-bits write
    assign cleared = mode & ~wdata;

    // Mode, personality flag and handoff pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= '0;
            active     <= 1'b0;
            legacy_clr <= 1'b0;
        end else begin
            legacy_clr <= 1'b0;
            if (unlock && !active) begin
                active <= 1'b1;
                mode   <= mode | STAT_MASK;
            end else if (clr_stb) begin
                mode <= cleared;
                if (cleared[STAT_BIT] == 1'b0) begin
                    active     <= 1'b0;
                    legacy_clr <= 1'b1;
                end
            end else if (set_stb) begin
                mode <= mode | wdata;
            end
        end
    end

endmodule

// File: rtl/enh_regfile.sv
// Module: enh_regfile (top)
// Enhanced-personality register file: phase register, clear/set mode
// register, auto-indexed parameter RAM and a status view of the active
// personality. Read data is registered and is zero after any non-read.
// Assumes the legacy decoder drives unlock_in for one cycle.
module enh_regfile
    import enh_regs_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PRAM_DEPTH = 16,
    parameter int unsigned STAT_BIT   = 6,
    localparam int unsigned IDX_W     = (PRAM_DEPTH > 1) ? $clog2(PRAM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_in,
    input  logic [3:0]        reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              enh_active,
    output logic              legacy_clr_req
);

    acc_t              acc;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] phase_q;
    logic [DATA_W-1:0] pram_q;
    logic [IDX_W-1:0]  pram_idx;
    logic [DATA_W-1:0] status_v;
    logic [DATA_W-1:0] rd_mux;

    enh_access_dec u_dec (
        .active (enh_active),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (reg_addr),
        .acc    (acc)
    );

    enh_mode_ctrl #(
        .DATA_W   (DATA_W),
        .STAT_BIT (STAT_BIT)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock     (unlock_in),
        .clr_stb    (acc.mode_clr),
        .set_stb    (acc.mode_set),
        .wdata      (wr_data),
        .mode       (mode_q),
        .active     (enh_active),
        .legacy_clr (legacy_clr_req)
    );

    enh_param_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (PRAM_DEPTH)
    ) u_pram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (acc.pram_wr),
        .rd      (acc.pram_rd),
        .idx_clr (acc.mode_clr),
        .wdata   (wr_data),
        .rdata   (pram_q),
        .idx     (pram_idx)
    );

    // Phase register load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (acc.phase_wr) begin
            phase_q <= wr_data;
        end
    end

    // Status view: all bits zero except the personality flag
    always_comb begin
        status_v           = '0;
        status_v[STAT_BIT] = enh_active;
    end

    // Read multiplexer; placeholder locations fall to zero
    always_comb begin
        case (reg_addr)
            A_RD_PARAM:  rd_mux = pram_q;
            A_RD_PHASE:  rd_mux = phase_q;
            A_RD_STATUS: rd_mux = status_v;
            A_RD_MODE:   rd_mux = mode_q;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data, zero when no qualified read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= acc.rd_ok ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/enh_regfile_chk.sv
// Module: enh_regfile_chk
// Assertion checker bound to enh_regfile. Observes ports plus the mode
// register and parameter index. Assumes synchronous active-low reset.
module enh_regfile_chk
    import enh_regs_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PRAM_DEPTH = 16,
    parameter int unsigned STAT_BIT   = 6,
    localparam int unsigned IDX_W     = (PRAM_DEPTH > 1) ? $clog2(PRAM_DEPTH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unlock_in,
    input logic [3:0]        reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              enh_active,
    input logic              legacy_clr_req,
    input logic [DATA_W-1:0] mode_q,
    input logic [IDX_W-1:0]  pram_idx
);

    localparam logic [IDX_W-1:0]  LAST     = IDX_W'(PRAM_DEPTH - 1);
    localparam logic [DATA_W-1:0] STAT_VAL = DATA_W'(1) << STAT_BIT;

    // R2
    unlock_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_in && !enh_active) |=> (enh_active && mode_q[STAT_BIT]));

    // R5
    idx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_active && wr_en && reg_addr == A_WR_MCLR) |=> (pram_idx == '0));

    // R6
    handoff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_clr_req |=> !legacy_clr_req);

    // R6
    handoff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enh_active) |-> legacy_clr_req);

    // R6
    handoff_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_clr_req |-> !enh_active);

    // R7
    pram_wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_active && wr_en && reg_addr == A_WR_PARAM)
        |=> (pram_idx == (($past(pram_idx) == LAST) ? '0 : $past(pram_idx) + 1'b1)));

    // R8
    pram_rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_active && rd_en && !wr_en && reg_addr == A_RD_PARAM)
        |=> (pram_idx == (($past(pram_idx) == LAST) ? '0 : $past(pram_idx) + 1'b1)));

    // R9
    status_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_active && rd_en && !wr_en && reg_addr == A_RD_STATUS) |=> (rd_data == STAT_VAL));

    // R10
    placeholder_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (reg_addr == A_RD_DATA || reg_addr == A_RD_MARK ||
                   reg_addr == A_RD_ERROR || reg_addr == A_RD_SETUP)) |=> (rd_data == '0));

    // R11
    inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_active |=> (rd_data == '0));

    // R12
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> (rd_data == '0));

endmodule

bind enh_regfile enh_regfile_chk #(
    .DATA_W     (DATA_W),
    .PRAM_DEPTH (PRAM_DEPTH),
    .STAT_BIT   (STAT_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .unlock_in      (unlock_in),
    .reg_addr       (reg_addr),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .rd_data        (rd_data),
    .enh_active     (enh_active),
    .legacy_clr_req (legacy_clr_req),
    .mode_q         (mode_q),
    .pram_idx       (pram_idx)
);

// File: tb/enh_regfile_bench.sv
// Bench for enh_regfile: behavioural reference model compared every clock,
// plus directed checks named by requirement.
module enh_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       unlock_in;
    logic [3:0] reg_addr;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       enh_active;
    logic       legacy_clr_req;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit model_on = 1'b0;

    // reference model state
    int m_ram [16];
    int m_idx, m_mode, m_phase, m_rd;
    bit m_act, m_exit;

    always #(CLK_PERIOD/2) clk = ~clk;

    enh_regfile u_enh_regfile (
        .clk            (clk),
        .rst_n          (rst_n),
        .unlock_in      (unlock_in),
        .reg_addr       (reg_addr),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .enh_active     (enh_active),
        .legacy_clr_req (legacy_clr_req)
    );

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int nrd;
        bit nexit;
        nrd = 0;
        nexit = 0;
        if (!rst_n) begin
            foreach (m_ram[i]) m_ram[i] = 0;
            m_idx = 0; m_mode = 0; m_phase = 0; m_act = 0;
        end else if (m_act && wr_en) begin
            case (reg_addr)
                3: begin m_ram[m_idx] = wr_data; m_idx = (m_idx + 1) % 16; end
                4: m_phase = wr_data;
                6: begin
                    m_mode = m_mode & ~int'(wr_data) & 255;
                    m_idx = 0;
                    if ((m_mode & 64) == 0) begin m_act = 0; nexit = 1; end
                end
                7: m_mode = m_mode | wr_data;
                default: ;
            endcase
        end else if (m_act && rd_en) begin
            case (reg_addr)
                11: begin nrd = m_ram[m_idx]; m_idx = (m_idx + 1) % 16; end
                12: nrd = m_phase;
                14: nrd = 64;
                15: nrd = m_mode;
                default: nrd = 0;
            endcase
        end else if (!m_act && unlock_in) begin
            m_act = 1;
            m_mode = m_mode | 64;
        end
        m_rd = nrd;
        m_exit = nexit;
    end

    // compare against the model every clock
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (rd_data !== 8'(m_rd) || enh_active !== m_act || legacy_clr_req !== m_exit) begin
                fails++;
                $display("FAIL %s model: actual rd=%h act=%b clr=%b expected rd=%h act=%b clr=%b",
                         cur_req, rd_data, enh_active, legacy_clr_req, 8'(m_rd), m_act, m_exit);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; unlock_in = 0; reg_addr = 0; wr_data = 0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic do_rd(input logic [3:0] a, input int exp, input string tag);
        reg_addr = a; rd_en = 1;
        @(negedge clk);
        idle();
        chk(tag, rd_data, exp);
    endtask

    task automatic do_unlock();
        unlock_in = 1;
        @(negedge clk);
        idle();
    endtask

    function automatic int pv(input int i);
        return (i * 37 + 5) & 255;
    endfunction

    initial begin
        begin : watchdog
            fork
                begin
                    repeat (20000) @(posedge clk);
                    fails++;
                    $display("FAIL R12 watchdog: actual=hung expected=done");
                    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
                    $finish;
                end
            join_none
        end
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 rd_data", rd_data, 0);
        chk("R1 active", enh_active, 0);
        chk("R1 clr", legacy_clr_req, 0);
        model_on = 1;

        cur_req = "R11";
        do_rd(4'd14, 0, "R11 status inactive");
        do_wr(4'd3, 8'h77);

        cur_req = "R2";
        do_unlock();
        chk("R2 active", enh_active, 1);
        do_rd(4'd15, 8'h40, "R2 mode bit6");
        do_rd(4'd11, 0, "R11 inactive param write ignored");

        cur_req = "R13";
        do_wr(4'd4, 8'h5A);
        do_rd(4'd12, 8'h5A, "R13 phase");

        cur_req = "R4";
        do_wr(4'd7, 8'h0F);
        do_rd(4'd15, 8'h4F, "R4 mode set");

        cur_req = "R3";
        do_wr(4'd6, 8'h03);
        do_rd(4'd15, 8'h4C, "R3 mode clear");
        chk("R3 still active", enh_active, 1);

        cur_req = "R7";
        do_wr(4'd6, 8'h00);
        for (int i = 0; i < 18; i++) do_wr(4'd3, 8'(pv(i)));
        do_rd(4'd11, pv(2), "R7 index wrapped to 2");

        cur_req = "R8";
        do_wr(4'd6, 8'h00);
        chk("R5 mode unchanged by zero clear", enh_active, 1);
        do_rd(4'd11, pv(16), "R5 index reset");
        do_rd(4'd11, pv(17), "R8 entry1");
        for (int k = 2; k < 16; k++) do_rd(4'd11, pv(k), "R8 sweep");
        do_rd(4'd11, pv(16), "R8 read wrap");

        cur_req = "R9";
        do_rd(4'd14, 8'h40, "R9 status");

        cur_req = "R10";
        do_wr(4'd0, 8'hFF);
        do_wr(4'd1, 8'hFF);
        do_wr(4'd2, 8'hFF);
        do_wr(4'd5, 8'hFF);
        do_rd(4'd8, 0, "R10 data");
        do_rd(4'd9, 0, "R10 mark");
        do_rd(4'd10, 0, "R10 error");
        do_rd(4'd13, 0, "R10 setup");
        do_rd(4'd15, 8'h4C, "R10 mode untouched");
        do_rd(4'd12, 8'h5A, "R10 phase untouched");
        do_wr(4'd6, 8'h00);
        do_rd(4'd11, pv(16), "R10 ram untouched");

        cur_req = "R12";
        reg_addr = 4'd4; wr_data = 8'h33; wr_en = 1; rd_en = 1;
        @(negedge clk);
        idle();
        chk("R12 write wins, no read data", rd_data, 0);
        do_rd(4'd12, 8'h33, "R12 write applied");
        @(negedge clk);
        chk("R12 idle zero", rd_data, 0);

        cur_req = "R2";
        do_unlock();
        do_rd(4'd15, 8'h4C, "R2 unlock while active");

        cur_req = "R6";
        do_wr(4'd6, 8'h40);
        chk("R6 active fell", enh_active, 0);
        chk("R6 clr pulse", legacy_clr_req, 1);
        @(negedge clk);
        chk("R6 pulse one cycle", legacy_clr_req, 0);
        cur_req = "R11";
        do_rd(4'd15, 0, "R11 read while inactive");
        do_wr(4'd3, 8'h99);
        do_unlock();
        do_rd(4'd15, 8'h4C, "R2 reentry mode");
        do_rd(4'd11, pv(16), "R6 ram survives handoff");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule